// File: doc/BRIEF.md
# Modulo-60 BCD Time Stage

This block is one two-digit decimal stage of a time-of-day counter, usable for either seconds or minutes. It holds a units digit and a tens digit in BCD. On every system clock cycle where the tick enable is high, the stage advances by one, stepping through 00, 01, ..., 59 and then back to 00. The whole design is synchronous to a single system clock. A count request arrives as a one-cycle enable, not as a clock edge derived from another counter's output bit.

The units digit counts 0 to 9. The tens digit moves only on a tick that finds the units digit at 9. On a tick that finds the stage at 59, the tens digit loads 0 directly, so the value 6 never appears on the outputs. On that same rollover the stage raises a one-cycle carry. To chain stages, wire the carry of a seconds stage to the tick enable of a minutes stage. The seconds stage itself is fed by a once-per-second enable.

A small phase state machine tracks where the stage sits in its cycle, and the carry is produced from that state. The three states are `ST_LOW` (units below 9), `ST_UNIT_TOP` (units at 9, tens below 5) and `ST_FULL` (count is 59). The transitions are:
- `ST_LOW` to `ST_UNIT_TOP`: a tick moves units from 8 to 9 while tens is below 5.
- `ST_LOW` to `ST_FULL`: a tick moves the count from 58 to 59.
- `ST_UNIT_TOP` to `ST_LOW`: a tick rolls units back to 0.
- `ST_FULL` to `ST_LOW`: a tick rolls the stage over to 00 and fires the carry.
- In any state, the machine holds while there is no tick.
- Reset forces `ST_LOW`.

Top module: `mod60_bcd_stage`

## Requirements
- R1: While `rst` is high at a clock edge, the next outputs are units 0, tens 0 and carry 0.
- R2: A tick with units below 9 raises units by exactly one on the next cycle.
- R3: A tick with units at 9 returns units to 0 on the next cycle.
- R4: Tens changes only on a tick that finds units at 9; on any other cycle, tens holds its value.
- R5: A tick that finds the count at 59 yields 00 on the next cycle; tens never shows 6.
- R6: `carry_out` is high for exactly one cycle, in the cycle the outputs first show 00 after a 59-to-00 tick. It is high at no other time, so 130 ticks from 00 produce exactly two carries.
- R7: A cycle with `tick_en` low leaves both digits unchanged and gives carry 0 on the next cycle.
- R8: Units never exceeds 9 and tens never exceeds 5.
- R9: Reset takes priority over a simultaneous tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle count request |
| units | output | 4 | BCD units digit (0 to 9) |
| tens | output | 4 | BCD tens digit (0 to 5) |
| carry_out | output | 1 | One-cycle rollover pulse for the next stage |

## Verification
The properties assume that `tick_en` and `rst` are settled before each rising edge. They also assume a tick may arrive on any cycle, including back-to-back cycles and cycles during reset. The stimulus uses several tick patterns: an unbroken run of 130 ticks from 00, sparse ticks separated by idle cycles, a reset asserted together with a tick, and a reset in the middle of a count. Because the driver changes inputs only on falling edges, every rising edge sees stable values. The phase-state consistency check relies on the digits being reachable only through ticks and reset, which is the only way the bench drives them.

// File: rtl/mod60_pkg.sv
package mod60_pkg;

    localparam int DIGIT_W = 4;

    typedef enum logic [1:0] {
        ST_LOW      = 2'd0,
        ST_UNIT_TOP = 2'd1,
        ST_FULL     = 2'd2
    } stage_phase_e;

endpackage

// File: rtl/bcd_digit.sv
module bcd_digit #(
    parameter int W     = 4,
    parameter int LIMIT = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    output logic [W-1:0] value,
    output logic         at_limit,
    output logic         at_prelimit
);
    localparam logic [W-1:0] TOP_V = LIMIT[W-1:0];
    localparam logic [W-1:0] PRE_V = TOP_V - 1'b1;

    logic [W-1:0] value_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            value_q <= '0;
        end else if (step) begin
            // load zero directly on the limit, never pass through LIMIT+1
            value_q <= (value_q == TOP_V) ? '0 : value_q + 1'b1;
        end
    end

    assign value       = value_q;
    assign at_limit    = (value_q == TOP_V);
    assign at_prelimit = (value_q == PRE_V);
endmodule

// File: rtl/stage_phase_fsm.sv
module stage_phase_fsm
    import mod60_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         units_pre,
    input  logic         tens_top,
    output stage_phase_e phase,
    output logic         carry
);
    stage_phase_e state_q, state_d;
    logic         carry_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOW: begin
                if (tick && units_pre) begin
                    state_d = tens_top ? ST_FULL : ST_UNIT_TOP;
                end
            end
            ST_UNIT_TOP: begin
                if (tick) state_d = ST_LOW;
            end
            ST_FULL: begin
                if (tick) state_d = ST_LOW;
            end
            default: state_d = ST_LOW;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_LOW;
        else     state_q <= state_d;
    end

    // output process: carry fires on the rollover out of the full state
    always_ff @(posedge clk) begin
        if (rst) carry_q <= 1'b0;
        else     carry_q <= tick && (state_q == ST_FULL);
    end

    assign phase = state_q;
    assign carry = carry_q;
endmodule

// File: rtl/mod60_bcd_stage.sv
module mod60_bcd_stage
    import mod60_pkg::*;
#(
    parameter int UNITS_MAX = 9,
    parameter int TENS_MAX  = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick_en,
    output logic [DIGIT_W-1:0] units,
    output logic [DIGIT_W-1:0] tens,
    output logic               carry_out
);
    logic         units_top, units_pre;
    logic         tens_top, tens_pre;
    logic         tens_step;
    stage_phase_e phase_q;

    bcd_digit #(.W(DIGIT_W), .LIMIT(UNITS_MAX)) u_units (
        .clk         (clk),
        .rst         (rst),
        .step        (tick_en),
        .value       (units),
        .at_limit    (units_top),
        .at_prelimit (units_pre)
    );

    assign tens_step = tick_en && units_top;

    bcd_digit #(.W(DIGIT_W), .LIMIT(TENS_MAX)) u_tens (
        .clk         (clk),
        .rst         (rst),
        .step        (tens_step),
        .value       (tens),
        .at_limit    (tens_top),
        .at_prelimit (tens_pre)
    );

    stage_phase_fsm u_phase (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick_en),
        .units_pre (units_pre),
        .tens_top  (tens_top),
        .phase     (phase_q),
        .carry     (carry_out)
    );

    logic unused_flags;
    assign unused_flags = tens_pre;
endmodule

// File: rtl/mod60_bcd_stage_chk.sv
module mod60_bcd_stage_chk
    import mod60_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               tick_en,
    input logic [DIGIT_W-1:0] units,
    input logic [DIGIT_W-1:0] tens,
    input logic               carry_out,
    input stage_phase_e       phase
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (units == 4'd0 && tens == 4'd0 && !carry_out));

    // R2
    units_step_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_en && units < 4'd9) |=> (units == $past(units) + 4'd1));

    // R3
    units_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_en && units == 4'd9) |=> (units == 4'd0));

    // R4
    tens_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(tick_en && units == 4'd9) |=> $stable(tens));

    // R5
    stage_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_en && units == 4'd9 && tens == 4'd5) |=> (units == 4'd0 && tens == 4'd0 && carry_out));

    // R6
    carry_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
        carry_out |-> (units == 4'd0 && tens == 4'd0));

    // R6
    carry_single_chk: assert property (@(posedge clk) disable iff (rst)
        carry_out |=> !carry_out);

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tick_en |=> ($stable(units) && $stable(tens) && !carry_out));

    // R8
    digit_range_chk: assert property (@(posedge clk) disable iff (rst)
        (units <= 4'd9 && tens <= 4'd5));

    // R6
    phase_match_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == ST_FULL) == (units == 4'd9 && tens == 4'd5));
endmodule

bind mod60_bcd_stage mod60_bcd_stage_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick_en   (tick_en),
    .units     (units),
    .tens      (tens),
    .carry_out (carry_out),
    .phase     (phase_q)
);

// File: tb/mod60_bcd_stage_tb.sv
module mod60_bcd_stage_tb;

    typedef struct {
        logic [3:0] u;
        logic [3:0] t;
        logic       c;
        string      req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b0;
    logic [3:0] units, tens;
    logic       carry_out;

    exp_t exp_q[$];
    int   checks = 0;
    int   fails  = 0;
    int   carries = 0;
    int   m_u = 0, m_t = 0;
    bit   done = 0;

    always #4 clk = ~clk;

    mod60_bcd_stage u_dut (
        .clk       (clk),
        .rst       (rst),
        .tick_en   (tick_en),
        .units     (units),
        .tens      (tens),
        .carry_out (carry_out)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic step(input bit t, input bit r);
        exp_t e;
        @(negedge clk);
        tick_en = t;
        rst     = r;
        @(posedge clk);
        #1;
        e.c = 1'b0;
        if (r) begin
            m_u = 0; m_t = 0;
            e.req = t ? "R9" : "R1";
        end else if (!t) begin
            e.req = "R7";
        end else if (m_u == 9) begin
            m_u = 0;
            if (m_t == 5) begin
                m_t = 0; e.c = 1'b1; e.req = "R5";
            end else begin
                m_t++; e.req = "R3";
            end
        end else begin
            m_u++; e.req = "R2";
        end
        e.u = 4'(m_u);
        e.t = 4'(m_t);
        exp_q.push_back(e);
    endtask

    // monitor: pops one expected item per cycle at the falling edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check(units == e.u, e.req, "units", int'(units), int'(e.u));
            check(tens == e.t, (e.req == "R3") ? "R4" : e.req, "tens", int'(tens), int'(e.t));
            check(carry_out == e.c, (e.c || e.req == "R7") ? e.req : "R6", "carry",
                  int'(carry_out), int'(e.c));
            check(units <= 4'd9 && tens <= 4'd5, "R8", "digit range",
                  int'(tens) * 10 + int'(units), 59);
            if (carry_out) carries++;
        end
    end

    initial begin
        step(1'b0, 1'b1);
        step(1'b1, 1'b1);
        step(1'b0, 1'b1);
        step(1'b0, 1'b0);
        carries = 0;
        for (int i = 0; i < 130; i++) step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        @(negedge clk);
        #1;
        // R6: 130 ticks from 00 give exactly two rollovers
        check(carries == 2, "R6", "carry count", carries, 2);
        for (int i = 0; i < 5; i++) step(1'b0, 1'b0);
        for (int i = 0; i < 70; i++) begin
            step(1'b1, 1'b0);
            step(1'b0, 1'b0);
            step(1'b0, 1'b0);
        end
        for (int i = 0; i < 13; i++) step(1'b1, 1'b0);
        step(1'b1, 1'b1);
        for (int i = 0; i < 12; i++) step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule